// File: doc/BRIEF.md
# Paged Display Memory with Icon Row

This block is the pixel store behind a small matrix display controller. It holds 65 rows of 132 single-bit pixels and shows them through two ports that work at the same time. The host port sees the store as pages of byte-wide columns. A 4-bit page register, loaded by a strobe, picks the page. Each access then reads or writes the eight vertically stacked pixels of one column in that page.

The scan port gives a row index and gets the whole 132-pixel row back one clock later. The display refresh logic can therefore read any row while the host rewrites the picture.

The first eight pages each cover eight rows. A ninth page covers a single extra row that holds status icons, and only data bit 0 maps onto it. Page numbers above the icon page and columns past the last one address nothing.

Top module: `dispmem_paged`

## Requirements
- R1: A write with page p in 0..7 and column c below 132 stores wdata bit b into row 8*p+b at column c, for b from 0 to 7. A later read of the same page and column returns that byte.
- R2: The page register clears to 0 on reset. It loads page_val only in a cycle where page_set is high, and holds its value otherwise.
- R3: A write to page 8 (binary 1000) stores only wdata bit 0, into row 64 at the addressed column. No other row changes.
- R4: A read of page 8 returns the row-64 pixel in rdata bit 0, with bits 7..1 equal to zero.
- R5: When the page register is above 8, or the column is 132 or more, a read returns 0x00 and a write changes no pixel.
- R6: rdata is registered. It shows the addressed byte in the cycle after rd_en is high and holds its value in cycles after rd_en is low. When a read and a write hit the same column and page in the same cycle, the read returns the data from before the write.
- R7: scan_data shows, one cycle after scan_row is sampled, the row with that index, with scan_data bit i equal to column i. A scan_row of 65 or more gives all zeros.
- R8: The scan port works in every cycle, whatever the host port does. When a write and a scan hit the same row in the same cycle, the scan returns the row as it was before the write.
- R9: After reset, rdata and scan_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_set | input | 1 | Strobe that loads the page register |
| page_val | input | 4 | New page number, taken when page_set is high |
| col | input | 8 | Host column address |
| wr_en | input | 1 | Host write request |
| wdata | input | 8 | Host write byte; bit b goes to row b of the page |
| rd_en | input | 1 | Host read request |
| rdata | output | 8 | Registered host read byte |
| scan_row | input | 7 | Display row to fetch |
| scan_data | output | 132 | Registered full row; bit i is column i |

## Verification
The bench builds the block with its default values: 132 columns, eight full pages of height eight, and the icon page enabled. This gives a 7-bit row index, so scan indices 65 to 127 exist as inputs and can be driven to check the zero result.

The 8-bit column and 4-bit page fields also leave room past the end of the store. Columns 132 to 255 and pages 9 to 15 can therefore be driven to show that out-of-range host traffic has no effect. Every row is compared through the scan port against a model kept in the bench.

// File: rtl/dispmem_pkg.sv
`timescale 1ns/1ps
package dispmem_pkg;
   localparam int unsigned DEF_COLS       = 132;
   localparam int unsigned DEF_FULL_PAGES = 8;
   localparam int unsigned DEF_PAGE_H     = 8;
   localparam int unsigned DEF_PA_W       = 4;
   localparam int unsigned DEF_CA_W       = 8;

   // Total row count: full pages plus an optional one-row icon page
   function automatic int unsigned rows_of(input int unsigned pages,
                                           input int unsigned height,
                                           input bit          icon);
      return pages * height + (icon ? 1 : 0);
   endfunction
endpackage

// File: rtl/dispmem_page_reg.sv
`timescale 1ns/1ps
module dispmem_page_reg #(
   parameter int unsigned PA_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            page_set,
   input  logic [PA_W-1:0] page_val,
   output logic [PA_W-1:0] page_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        page_q <= '0;
      else if (page_set) page_q <= page_val;
   end

   a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !page_set |=> page_q == $past(page_q));
   a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
      page_set |=> page_q == $past(page_val));
endmodule

// File: rtl/dispmem_decode.sv
`timescale 1ns/1ps
module dispmem_decode #(
   parameter int unsigned COLS       = 132,
   parameter int unsigned FULL_PAGES = 8,
   parameter int unsigned PAGE_H     = 8,
   parameter bit          ICON_PAGE  = 1'b1,
   parameter int unsigned PA_W       = 4,
   parameter int unsigned CA_W       = 8,
   parameter int unsigned ROW_W      = 7
) (
   input  logic [PA_W-1:0]  page_q,
   input  logic [CA_W-1:0]  col,
   output logic             acc_ok,
   output logic             icon,
   output logic [ROW_W-1:0] base_row
);
   logic col_ok;
   logic page_ok;

   assign col_ok   = int'(col) < COLS;
   assign base_row = ROW_W'(int'(page_q) * PAGE_H);

   if (ICON_PAGE) begin : g_icon
      assign icon    = int'(page_q) == FULL_PAGES;
      assign page_ok = int'(page_q) <= FULL_PAGES;
   end else begin : g_no_icon
      assign icon    = 1'b0;
      assign page_ok = int'(page_q) < FULL_PAGES;
   end

   assign acc_ok = page_ok & col_ok;
endmodule

// File: rtl/dispmem_array.sv
`timescale 1ns/1ps
module dispmem_array #(
   parameter int unsigned COLS   = 132,
   parameter int unsigned ROWS   = 65,
   parameter int unsigned PAGE_H = 8,
   parameter int unsigned CA_W   = 8,
   parameter int unsigned ROW_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              icon,
   input  logic [ROW_W-1:0]  base_row,
   input  logic [CA_W-1:0]   col,
   input  logic [PAGE_H-1:0] wdata,
   output logic [PAGE_H-1:0] rbyte,
   input  logic [ROW_W-1:0]  scan_row,
   output logic [COLS-1:0]   scan_data
);
   logic [COLS-1:0] mem [ROWS];

   // Column write: the icon page only keeps data bit 0
   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < PAGE_H; b++) begin
            if (b == 0 || !icon)
               mem[base_row + ROW_W'(b)][col] <= wdata[b];
         end
      end
   end

   always_comb begin
      rbyte = '0;
      for (int b = 0; b < PAGE_H; b++) begin
         if (b == 0 || !icon)
            rbyte[b] = mem[base_row + ROW_W'(b)][col];
      end
   end

   // Row fetch sees the array before any same-edge write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     scan_data <= '0;
      else if (int'(scan_row) < ROWS) scan_data <= mem[scan_row];
      else                            scan_data <= '0;
   end

   a_r7_scan_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      int'(scan_row) >= ROWS |=> scan_data == '0);
endmodule

// File: rtl/dispmem_paged.sv
`timescale 1ns/1ps
module dispmem_paged
   import dispmem_pkg::*;
#(
   parameter int unsigned COLS       = DEF_COLS,
   parameter int unsigned FULL_PAGES = DEF_FULL_PAGES,
   parameter int unsigned PAGE_H     = DEF_PAGE_H,
   parameter bit          ICON_PAGE  = 1'b1,
   parameter int unsigned PA_W       = DEF_PA_W,
   parameter int unsigned CA_W       = DEF_CA_W,
   localparam int unsigned ROWS      = rows_of(FULL_PAGES, PAGE_H, ICON_PAGE),
   localparam int unsigned ROW_W     = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_set,
   input  logic [PA_W-1:0]   page_val,
   input  logic [CA_W-1:0]   col,
   input  logic              wr_en,
   input  logic [PAGE_H-1:0] wdata,
   input  logic              rd_en,
   output logic [PAGE_H-1:0] rdata,
   input  logic [ROW_W-1:0]  scan_row,
   output logic [COLS-1:0]   scan_data
);
   if (COLS > (1 << CA_W)) begin : g_bad_cols
      $fatal(1, "column field too narrow for COLS");
   end
   if (FULL_PAGES + 1 > (1 << PA_W)) begin : g_bad_pages
      $fatal(1, "page field too narrow for page count");
   end
   if (PAGE_H < 2) begin : g_bad_height
      $fatal(1, "page height must be at least 2");
   end

   logic [PA_W-1:0]   page_q;
   logic              acc_ok;
   logic              icon;
   logic [ROW_W-1:0]  base_row;
   logic [PAGE_H-1:0] rbyte;

   dispmem_page_reg #(.PA_W(PA_W)) u_page (
      .clk(clk), .rst_n(rst_n), .page_set(page_set),
      .page_val(page_val), .page_q(page_q));

   dispmem_decode #(
      .COLS(COLS), .FULL_PAGES(FULL_PAGES), .PAGE_H(PAGE_H),
      .ICON_PAGE(ICON_PAGE), .PA_W(PA_W), .CA_W(CA_W), .ROW_W(ROW_W)
   ) u_dec (
      .page_q(page_q), .col(col), .acc_ok(acc_ok),
      .icon(icon), .base_row(base_row));

   dispmem_array #(
      .COLS(COLS), .ROWS(ROWS), .PAGE_H(PAGE_H), .CA_W(CA_W), .ROW_W(ROW_W)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en & acc_ok), .icon(icon),
      .base_row(base_row), .col(col), .wdata(wdata), .rbyte(rbyte),
      .scan_row(scan_row), .scan_data(scan_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= acc_ok ? rbyte : '0;
   end

   a_r5_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !acc_ok |=> rdata == '0);
   a_r4_icon_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && acc_ok && icon |=> rdata[PAGE_H-1:1] == '0);
   a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_dispmem_paged.sv
`timescale 1ns/1ps
module tb_dispmem_paged;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         page_set = 1'b0;
   logic [3:0]   page_val = '0;
   logic [7:0]   col = '0;
   logic         wr_en = 1'b0;
   logic [7:0]   wdata = '0;
   logic         rd_en = 1'b0;
   logic [7:0]   rdata;
   logic [6:0]   scan_row = '0;
   logic [131:0] scan_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [131:0] m [65];
   logic [3:0]   bpage = '0;

   always #10 clk = ~clk;   // 50 MHz

   dispmem_paged dut (
      .clk(clk), .rst_n(rst_n), .page_set(page_set), .page_val(page_val),
      .col(col), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
      .scan_row(scan_row), .scan_data(scan_data));

   // page, column, write byte, expected read-back
   localparam logic [27:0] VEC [10] = '{
      {4'd0, 8'd0,   8'hA5, 8'hA5},
      {4'd7, 8'd131, 8'h3C, 8'h3C},
      {4'd3, 8'd64,  8'hFF, 8'hFF},
      {4'd8, 8'd17,  8'hFF, 8'h01},
      {4'd8, 8'd131, 8'hFE, 8'h00},
      {4'd9, 8'd5,   8'hFF, 8'h00},
      {4'd15,8'd0,   8'hFF, 8'h00},
      {4'd1, 8'd132, 8'hFF, 8'h00},
      {4'd1, 8'd200, 8'h77, 8'h00},
      {4'd5, 8'd99,  8'h81, 8'h81}
   };

   task automatic chk(input string tag, input logic [131:0] act, input logic [131:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_pg(input logic [3:0] p);
      page_val = p; page_set = 1'b1;
      @(negedge clk); page_set = 1'b0;
      bpage = p;
   endtask

   task automatic model_wr(input logic [7:0] c, input logic [7:0] d);
      if (c < 132) begin
         if (bpage < 8)
            for (int b = 0; b < 8; b++) m[bpage*8+b][c] = d[b];
         else if (bpage == 8)
            m[64][c] = d[0];
      end
   endtask

   task automatic wr(input logic [7:0] c, input logic [7:0] d);
      col = c; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      model_wr(c, d);
   endtask

   task automatic rd(input logic [7:0] c, output logic [7:0] r);
      col = c; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      r = rdata;
   endtask

   task automatic scan_all(input string tag);
      for (int r = 0; r < 65; r++) begin
         scan_row = 7'(r);
         @(negedge clk);
         chk(tag, scan_data, m[r]);
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [131:0] old_row;
      repeat (3) @(negedge clk);
      // R9: reset values
      chk("R9 rdata", 132'(rdata), '0);
      chk("R9 scan", scan_data, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // Fill every reachable pixel with zero
      for (int p = 0; p < 9; p++) begin
         set_pg(4'(p));
         for (int c = 0; c < 132; c++) wr(8'(c), 8'h00);
      end

      // Vector walk: R1, R3, R4, R5
      for (int i = 0; i < 10; i++) begin
         logic [3:0] vp; logic [7:0] vc, vd, ve;
         {vp, vc, vd, ve} = VEC[i];
         set_pg(vp);
         wr(vc, vd);
         rd(vc, r);
         if (vp == 4'd8)                 chk("R3 R4 icon page", 132'(r), 132'(ve));
         else if (vp > 4'd8 || vc > 131) chk("R5 out of range", 132'(r), 132'(ve));
         else                            chk("R1 page byte", 132'(r), 132'(ve));
      end
      // R5 R1 R3 R7: every row matches the model
      scan_all("R7 row image");

      // R7: scan rows past the end
      scan_row = 7'd65;  @(negedge clk); chk("R7 row 65", scan_data, '0);
      scan_row = 7'd127; @(negedge clk); chk("R7 row 127", scan_data, '0);

      // R2: page_val without strobe is ignored
      set_pg(4'd7);
      page_val = 4'd2;
      @(negedge clk);
      rd(8'd131, r);
      chk("R2 hold", 132'(r), 132'h3C);

      // R2: reset returns page register to 0
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      bpage = 4'd0;
      chk("R9 rdata after reset", 132'(rdata), '0);
      rd(8'd0, r);
      chk("R2 reset page", 132'(r), 132'hA5);

      // R6: hold when rd_en low
      col = 8'd99; @(negedge clk);
      chk("R6 hold", 132'(rdata), 132'hA5);

      // R6: read and write same place same cycle sees old
      col = 8'd0; wdata = 8'h5A; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      model_wr(8'd0, 8'h5A);
      chk("R6 read before write", 132'(rdata), 132'hA5);
      rd(8'd0, r);
      chk("R6 new data", 132'(r), 132'h5A);

      // R8: scan same row as write returns old row
      set_pg(4'd2);
      old_row = m[16];
      col = 8'd10; wdata = 8'h01; wr_en = 1'b1; scan_row = 7'd16;
      @(negedge clk); wr_en = 1'b0;
      model_wr(8'd10, 8'h01);
      chk("R8 scan old", scan_data, old_row);
      @(negedge clk);
      chk("R8 scan new", scan_data, m[16]);

      // R3: icon write of 0 clears only row 64 pixel
      set_pg(4'd8);
      wr(8'd17, 8'hFE);
      rd(8'd17, r);
      chk("R4 icon clear", 132'(r), '0);
      scan_all("R3 rows after icon write");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule